// File: doc/BRIEF.md
# Cascadable Serial-Load Switch Control Register

This block drives the enable bits for a bank of on/off switches. It takes one control bit per accepted beat on a serial stream and moves it through a chain of flip-flops, one stage per channel. The last stage drives a cascade output, so several of these blocks can be chained by feeding one block's cascade output into the next block's serial input. A freeze stage sits between the chain and the switch enables. While the freeze input is low, the enables follow the chain. When the freeze input goes high, the enables keep the chain value they had at that moment. A clear input forces every enable off without disturbing the stored data.

Everything runs on one system clock. A serial beat is a single cycle in which ser_valid is high, sampled on the rising edge. The block never applies back-pressure: ser_ready is high whenever reset is released, so each cycle with ser_valid high shifts exactly one bit. Clear and freeze are plain level inputs, and the switch enables respond to them combinationally.

Top module: `sw_ctl_reg`

## Requirements
- R1: During reset and in the cycle after it, all switch enables and the cascade output are 0, and the chain and the held copy both contain zero.
- R2: ser_ready is 1 outside reset. On each rising edge with ser_valid high, ser_data enters stage 0 and every stage takes the value of the stage below it. A cycle with ser_valid low leaves the chain unchanged.
- R3: casc_out equals the content of the top stage (stage CHANNELS-1) at all times.
- R4: While latch_hold is 0 and clr is 0, sw_en[n] equals chain stage n. It updates right after each shifting edge.
- R5: While latch_hold is 1, sw_en keeps the chain value present when latch_hold rose. Shifting during this time does not change any enable.
- R6: While clr is 1, sw_en is all zeros, whatever the values of ser_data, ser_valid and latch_hold.
- R7: clr changes neither the chain nor the held copy. When clr falls, sw_en shows the same value it would have shown had clr stayed low.
- R8: Channels are independent. A 1 in stage n turns on switch n (sw_en bit n) and nothing else, so a lone 1 shifted CHANNELS-1 places appears only on the top channel and on casc_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_valid | input | 1 | Serial beat present |
| ser_ready | output | 1 | Beat accepted. High whenever reset is released |
| ser_data | input | 1 | Serial control bit |
| latch_hold | input | 1 | 0: enables follow the chain, 1: enables frozen |
| clr | input | 1 | Forces all enables off, level sensitive |
| casc_out | output | 1 | Top chain stage, feeds the next block's ser_data |
| sw_en | output | CHANNELS | Active-high switch enables, bit n for channel n |

## Verification
A shifting beat takes effect at the first rising edge on which it is present. The bench therefore drives each beat at a falling edge and samples casc_out and sw_en one nanosecond after the next rising edge, which is the point where both outputs already show the new value in follow mode. Changes to clr and latch_hold act combinationally and need no clock edge. The bench applies them at a falling edge and reads the outputs in that same sample window, so a freeze that fails to block the shift taken at that edge is caught at once. For each row of the vector table, the expected value is the result after exactly one edge.

// File: rtl/sw_ctl_pkg.sv
package sw_ctl_pkg;
  localparam int unsigned DEFAULT_CHANNELS = 8;

  typedef enum logic {
    LATCH_FOLLOW = 1'b0,
    LATCH_FREEZE = 1'b1
  } latch_mode_e;

  function automatic latch_mode_e mode_of(input logic hold);
    return hold ? LATCH_FREEZE : LATCH_FOLLOW;
  endfunction
endpackage

// File: rtl/sw_shift_chain.sv
module sw_shift_chain #(
  parameter int unsigned CHANNELS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic                bit_in,
  output logic [CHANNELS-1:0] stage_q,
  output logic [CHANNELS-1:0] stage_d
);
  localparam int unsigned TOP = CHANNELS - 1;

  always_comb begin
    stage_d = stage_q;
    if (accept) stage_d = {stage_q[TOP-1:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  // R2
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (stage_q[TOP:1] == $past(stage_q[TOP-1:0])) && (stage_q[0] == $past(bit_in)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(stage_q));
endmodule

// File: rtl/sw_latch_bank.sv
module sw_latch_bank
  import sw_ctl_pkg::*;
#(
  parameter int unsigned CHANNELS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hold,
  input  logic [CHANNELS-1:0] chain_q,
  input  logic [CHANNELS-1:0] chain_d,
  output logic [CHANNELS-1:0] view
);
  logic [CHANNELS-1:0] held_q;
  latch_mode_e         mode;

  assign mode = mode_of(hold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    held_q <= '0;
    else if (mode == LATCH_FOLLOW) held_q <= chain_d;
  end

  for (genvar n = 0; n < CHANNELS; n++) begin : g_chan
    assign view[n] = (mode == LATCH_FREEZE) ? held_q[n] : chain_q[n];
  end

  // R5
  latch_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold)) |-> $stable(view));
endmodule

// File: rtl/sw_clear_gate.sv
module sw_clear_gate #(
  parameter int unsigned CHANNELS = 8
) (
  input  logic                clr,
  input  logic [CHANNELS-1:0] en_in,
  output logic [CHANNELS-1:0] en_out
);
  for (genvar n = 0; n < CHANNELS; n++) begin : g_gate
    assign en_out[n] = en_in[n] & ~clr;
  end
endmodule

// File: rtl/sw_ctl_reg.sv
module sw_ctl_reg
  import sw_ctl_pkg::*;
#(
  parameter int unsigned CHANNELS = DEFAULT_CHANNELS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_valid,
  output logic                ser_ready,
  input  logic                ser_data,
  input  logic                latch_hold,
  input  logic                clr,
  output logic                casc_out,
  output logic [CHANNELS-1:0] sw_en
);
  localparam int unsigned TOP = CHANNELS - 1;

  logic [CHANNELS-1:0] chain_q;
  logic [CHANNELS-1:0] chain_d;
  logic [CHANNELS-1:0] latched;
  logic                accept;

  assign ser_ready = rst_n;
  assign accept    = ser_valid & ser_ready;
  assign casc_out  = chain_q[TOP];

  sw_shift_chain #(.CHANNELS(CHANNELS)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .bit_in  (ser_data),
    .stage_q (chain_q),
    .stage_d (chain_d)
  );

  sw_latch_bank #(.CHANNELS(CHANNELS)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (latch_hold),
    .chain_q (chain_q),
    .chain_d (chain_d),
    .view    (latched)
  );

  sw_clear_gate #(.CHANNELS(CHANNELS)) u_clear (
    .clr    (clr),
    .en_in  (latched),
    .en_out (sw_en)
  );

  // R6
  clear_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> (sw_en == '0));

  // R3
  casc_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_hold && !clr) |-> (sw_en[TOP] == casc_out));
endmodule

// File: tb/test_sw_ctl_reg.sv
module test_sw_ctl_reg;
  localparam int CH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_valid = 1'b0;
  logic ser_data = 1'b0;
  logic latch_hold = 1'b0;
  logic clr = 1'b0;
  logic ser_ready;
  logic casc_out;
  logic [CH-1:0] sw_en;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sw_ctl_reg #(.CHANNELS(CH)) i_sw_ctl_reg (
    .clk(clk), .rst_n(rst_n), .ser_valid(ser_valid), .ser_ready(ser_ready),
    .ser_data(ser_data), .latch_hold(latch_hold), .clr(clr),
    .casc_out(casc_out), .sw_en(sw_en)
  );

  // row: clr, hold, valid, data, expected sw_en, expected casc_out
  typedef struct packed {
    logic c; logic h; logic v; logic d; logic [7:0] sw; logic cas;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b1,1'b1,8'h01,1'b0},  // R2 R4
    '{1'b0,1'b0,1'b1,1'b0,8'h02,1'b0},  // R2 R4
    '{1'b0,1'b0,1'b1,1'b1,8'h05,1'b0},  // R4
    '{1'b0,1'b0,1'b0,1'b1,8'h05,1'b0},  // R2 idle
    '{1'b0,1'b1,1'b1,1'b1,8'h05,1'b0},  // R5 freeze
    '{1'b0,1'b1,1'b1,1'b0,8'h05,1'b0},  // R5
    '{1'b1,1'b1,1'b1,1'b1,8'h00,1'b0},  // R6
    '{1'b0,1'b1,1'b0,1'b0,8'h05,1'b0},  // R7
    '{1'b0,1'b0,1'b1,1'b1,8'h5B,1'b0},  // R4 release
    '{1'b0,1'b0,1'b1,1'b0,8'hB6,1'b1},  // R3
    '{1'b1,1'b0,1'b1,1'b1,8'h00,1'b0},  // R6
    '{1'b0,1'b0,1'b0,1'b0,8'h6D,1'b0},  // R7
    '{1'b0,1'b0,1'b1,1'b1,8'hDB,1'b1}   // R3 R8
  };

  task automatic chk(input string tag, input logic [CH-1:0] got, input logic [CH-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic beat(input logic c, input logic h, input logic v, input logic d);
    @(negedge clk);
    clr = c; latch_hold = h; ser_valid = v; ser_data = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 enables in reset", sw_en, '0);
    chk("R1 cascade in reset", {7'b0, casc_out}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 enables after reset", sw_en, '0);
    chk("R2 ready high", {7'b0, ser_ready}, 8'h01);

    for (int i = 0; i < NV; i++) begin
      beat(VECS[i].c, VECS[i].h, VECS[i].v, VECS[i].d);
      chk($sformatf("R4/R5/R6/R7 row %0d sw_en", i), sw_en, VECS[i].sw);
      chk($sformatf("R3 row %0d casc_out", i), {7'b0, casc_out}, {7'b0, VECS[i].cas});
    end

    // R7: clear during follow mode, then release without any edge
    @(negedge clk); clr = 1'b1; ser_valid = 1'b0;
    #1 chk("R6 clear combinational", sw_en, '0);
    @(negedge clk); clr = 1'b0;
    #1 chk("R7 data kept under clear", sw_en, 8'hDB);

    // R1: reset mid-run clears chain
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R1 reset clears enables", sw_en, '0);
    chk("R1 reset clears cascade", {7'b0, casc_out}, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    // R8: lone 1 walks to the top
    beat(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R8 lone bit at channel 0", sw_en, 8'h01);
    for (int k = 1; k < CH; k++) begin
      beat(1'b0, 1'b0, 1'b1, 1'b0);
      chk($sformatf("R8 lone bit at channel %0d", k), sw_en, 8'h01 << k);
    end
    chk("R3 lone bit on cascade", {7'b0, casc_out}, 8'h01);
    beat(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R3 lone bit leaves", {7'b0, casc_out}, 8'h00);
    chk("R8 chain empty", sw_en, 8'h00);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule